// File: doc/BRIEF.md
# Configuration Bit Position Calculator

This unit turns the location of one bit inside a block memory into its place in the device's configuration data. A request carries the bit index `j` inside the block and the block's grid column and row. The unit answers with four coordinates: the major (column) address, the minor (frame) address, a signed byte offset counted from the start of the column, and a bit offset inside that byte. The device description is supplied on static inputs: the number of memory rows, the frame length in 32-bit words and a signed device-specific correction.

The block column index is not the major address itself. A small table, written before use through a dedicated write port, turns each column index into its major address. The computation is split into a two-stage pipeline. It takes one request per clock and returns answers in the order they were accepted, with a valid flag. A byte offset that comes out below zero is returned as-is and also raises an error flag.

Top module: `cfgbit_locator`

## Requirements
- R1: After reset `rsp_valid` is low and every entry of the column-to-major table reads as zero.
- R2: A request accepted on a rising edge with `req_valid` high produces exactly one response, with `rsp_valid` high after the second rising edge. Back-to-back requests are accepted every cycle and answered in request order. No response appears without a request.
- R3: `rsp_minor` equals `j` shifted right by 8, which is the frame number inside the column.
- R4: `rsp_major` equals the table entry at index `req_x`. A write with `map_we` high stores `map_val` at `map_idx` on the rising edge and is seen by requests accepted on later edges.
- R5: The byte offset includes a lane term chosen by `j[3:0]`. For the index values 0 to 15 in turn, the term is 6, 4, 2, 0, -4, -6, -8, -10, -16, -18, -20, -22, -26, -28, -30, -32.
- R6: When `j[4]` is 1 the byte offset is lowered by one more. When `j[4]` is 0 it is not.
- R7: The byte offset includes `minor × dev_flen × 4`, because a configuration word is four bytes.
- R8: Let `s = j[7:5]`. Let p(s) be the value for `s` in the order 0 to 7 of the list 3, 2, 1, 0, 4, 5, 6, 7. `rsp_bit` is p(s) when `j[4]` is 0 and 7 − p(s) when `j[4]` is 1.
- R9: `rsp_byte` is a 24-bit two's-complement value. `rsp_neg` is high exactly when that value is below zero.
- R10: The column base term is `(dev_rows − req_y) × 40 + 80 + dev_k`, with `dev_k` signed. A row above `dev_rows` gives a negative contribution rather than a wrapped one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_we | input | 1 | Write enable for the column-to-major table |
| map_idx | input | 4 | Table index (block column) |
| map_val | input | 8 | Major address to store |
| req_valid | input | 1 | Request present this cycle |
| req_bit | input | 16 | Bit index `j` inside the block |
| req_x | input | 4 | Block grid column |
| req_y | input | 6 | Block grid row |
| dev_rows | input | 6 | Number of memory rows on the device |
| dev_flen | input | 8 | Frame length in words |
| dev_k | input | 12 | Signed device offset |
| rsp_valid | output | 1 | Response present |
| rsp_major | output | 8 | Major (column) address |
| rsp_minor | output | 8 | Minor (frame) address |
| rsp_byte | output | 24 | Signed byte offset within the column |
| rsp_bit | output | 3 | Bit offset within the byte |
| rsp_neg | output | 1 | Byte offset is negative |

## Verification
The bench sweeps all 32 positions of two neighbouring 16-bit groups back to back. A swapped or shifted lane table, or a lane term or bit mirror that keys on the wrong bit of `j`, would therefore give wrong offsets on half of the indices. It walks the bit selector through all eight values in both group parities, so a mirror applied to the wrong group shows up as `rsp_bit` values reflected around 3.5. Requests with multi-frame indices and different frame lengths expose a frame term that forgets the factor of four. Rows above the row count, combined with a negative device offset, expose unsigned wrap-around and a missing error flag. A table write followed at once by a lookup catches a table that stores to the wrong entry.

// File: rtl/cfgbit_pkg.sv
package cfgbit_pkg;

    localparam int LANE_W = 7;

    // signed byte step for each of the 16 bit lanes of a group
    function automatic logic signed [LANE_W-1:0] lane_step(input logic [3:0] lane);
        logic signed [LANE_W-1:0] r;
        unique case (lane)
            4'd0:  r = 7'sd6;
            4'd1:  r = 7'sd4;
            4'd2:  r = 7'sd2;
            4'd3:  r = 7'sd0;
            4'd4:  r = -7'sd4;
            4'd5:  r = -7'sd6;
            4'd6:  r = -7'sd8;
            4'd7:  r = -7'sd10;
            4'd8:  r = -7'sd16;
            4'd9:  r = -7'sd18;
            4'd10: r = -7'sd20;
            4'd11: r = -7'sd22;
            4'd12: r = -7'sd26;
            4'd13: r = -7'sd28;
            4'd14: r = -7'sd30;
            default: r = -7'sd32;
        endcase
        return r;
    endfunction

    // bit position inside the byte for each selector value
    function automatic logic [2:0] sel_bitpos(input logic [2:0] sel);
        logic [2:0] r;
        unique case (sel)
            3'd0: r = 3'd3;
            3'd1: r = 3'd2;
            3'd2: r = 3'd1;
            3'd3: r = 3'd0;
            3'd4: r = 3'd4;
            3'd5: r = 3'd5;
            3'd6: r = 3'd6;
            default: r = 3'd7;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfgbit_major_map.sv
module cfgbit_major_map #(
    parameter int IDX_W = 4,
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VAL_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VAL_W-1:0] rd_val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [VAL_W-1:0] tbl [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_val;
        end
    end

    assign rd_val = tbl[rd_idx];
endmodule

// File: rtl/cfgbit_lane_decode.sv
module cfgbit_lane_decode
    import cfgbit_pkg::*;
(
    input  logic [7:0]               low_bits,
    output logic signed [LANE_W-1:0] lane_off,
    output logic [2:0]               bit_off
);
    logic odd_group;
    logic [2:0] base_pos;
    logic signed [LANE_W-1:0] step;

    always_comb begin
        odd_group = low_bits[4];
        step      = lane_step(low_bits[3:0]);
        base_pos  = sel_bitpos(low_bits[7:5]);
        lane_off  = odd_group ? (step - 7'sd1) : step;
        bit_off   = odd_group ? (3'd7 - base_pos) : base_pos;
    end
endmodule

// File: rtl/cfgbit_column_base.sv
module cfgbit_column_base #(
    parameter int ROWS_W = 6,
    parameter int Y_W    = 6,
    parameter int K_W    = 12,
    parameter int MNA_W  = 8,
    parameter int FLEN_W = 8,
    parameter int OFF_W  = 24
) (
    input  logic [ROWS_W-1:0]       rows,
    input  logic [Y_W-1:0]          row_y,
    input  logic signed [K_W-1:0]   dev_k,
    input  logic [MNA_W-1:0]        minor,
    input  logic [FLEN_W-1:0]       flen,
    output logic signed [OFF_W-1:0] row_term,
    output logic signed [OFF_W-1:0] frame_term
);
    localparam int PROD_W = MNA_W + FLEN_W;
    localparam logic signed [OFF_W-1:0] ROW_BASE = OFF_W'(80);

    logic signed [OFF_W-1:0] span;
    logic signed [OFF_W-1:0] k_ext;
    logic [PROD_W-1:0]       words;

    always_comb begin
        span  = $signed({{(OFF_W-ROWS_W){1'b0}}, rows}) - $signed({{(OFF_W-Y_W){1'b0}}, row_y});
        k_ext = {{(OFF_W-K_W){dev_k[K_W-1]}}, dev_k};
        // 40 = 32 + 8
        row_term = (span <<< 5) + (span <<< 3) + ROW_BASE + k_ext;
        words      = minor * flen;
        frame_term = $signed({{(OFF_W-PROD_W-2){1'b0}}, words, 2'b00});
    end
endmodule

// File: rtl/cfgbit_locator.sv
module cfgbit_locator
    import cfgbit_pkg::*;
#(
    parameter int J_W    = 16,
    parameter int X_W    = 4,
    parameter int Y_W    = 6,
    parameter int ROWS_W = 6,
    parameter int FLEN_W = 8,
    parameter int K_W    = 12,
    parameter int MJA_W  = 8,
    parameter int OFF_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    map_we,
    input  logic [X_W-1:0]          map_idx,
    input  logic [MJA_W-1:0]        map_val,
    input  logic                    req_valid,
    input  logic [J_W-1:0]          req_bit,
    input  logic [X_W-1:0]          req_x,
    input  logic [Y_W-1:0]          req_y,
    input  logic [ROWS_W-1:0]       dev_rows,
    input  logic [FLEN_W-1:0]       dev_flen,
    input  logic signed [K_W-1:0]   dev_k,
    output logic                    rsp_valid,
    output logic [MJA_W-1:0]        rsp_major,
    output logic [J_W-9:0]          rsp_minor,
    output logic signed [OFF_W-1:0] rsp_byte,
    output logic [2:0]              rsp_bit,
    output logic                    rsp_neg
);
    localparam int MNA_W = J_W - 8;

    logic [MJA_W-1:0]         major_c;
    logic [MNA_W-1:0]         minor_c;
    logic signed [LANE_W-1:0] lane_c;
    logic [2:0]               bit_c;
    logic signed [OFF_W-1:0]  row_c, frame_c;

    assign minor_c = req_bit[J_W-1:8];

    cfgbit_major_map #(.IDX_W(X_W), .VAL_W(MJA_W)) map_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(map_we), .wr_idx(map_idx), .wr_val(map_val),
        .rd_idx(req_x), .rd_val(major_c)
    );

    cfgbit_lane_decode lane_i (
        .low_bits(req_bit[7:0]), .lane_off(lane_c), .bit_off(bit_c)
    );

    cfgbit_column_base #(
        .ROWS_W(ROWS_W), .Y_W(Y_W), .K_W(K_W),
        .MNA_W(MNA_W), .FLEN_W(FLEN_W), .OFF_W(OFF_W)
    ) base_i (
        .rows(dev_rows), .row_y(req_y), .dev_k(dev_k),
        .minor(minor_c), .flen(dev_flen),
        .row_term(row_c), .frame_term(frame_c)
    );

    // stage 1: decoded terms
    logic                     s1_valid;
    logic [MJA_W-1:0]         s1_major;
    logic [MNA_W-1:0]         s1_minor;
    logic signed [LANE_W-1:0] s1_lane;
    logic [2:0]               s1_bit;
    logic signed [OFF_W-1:0]  s1_row, s1_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_major <= '0;
            s1_minor <= '0;
            s1_lane  <= '0;
            s1_bit   <= '0;
            s1_row   <= '0;
            s1_frame <= '0;
        end else begin
            s1_valid <= req_valid;
            s1_major <= major_c;
            s1_minor <= minor_c;
            s1_lane  <= lane_c;
            s1_bit   <= bit_c;
            s1_row   <= row_c;
            s1_frame <= frame_c;
        end
    end

    // stage 2: final sum
    logic signed [OFF_W-1:0] sum_c;
    assign sum_c = s1_row + s1_frame + {{(OFF_W-LANE_W){s1_lane[LANE_W-1]}}, s1_lane};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_major <= '0;
            rsp_minor <= '0;
            rsp_byte  <= '0;
            rsp_bit   <= '0;
            rsp_neg   <= 1'b0;
        end else begin
            rsp_valid <= s1_valid;
            rsp_major <= s1_major;
            rsp_minor <= s1_minor;
            rsp_byte  <= sum_c;
            rsp_bit   <= s1_bit;
            rsp_neg   <= sum_c[OFF_W-1];
        end
    end
endmodule

// File: rtl/cfgbit_locator_chk.sv
module cfgbit_locator_chk #(
    parameter int J_W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [J_W-1:0] req_bit,
    input logic           rsp_valid,
    input logic [J_W-9:0] rsp_minor,
    input logic [2:0]     rsp_bit
);
    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ##1 !rsp_valid);

    // R3
    minor_tracks_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_minor == $past(req_bit[J_W-1:8], 2));

    // R8
    bit_half_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_bit[2] == $past(req_bit[7] ^ req_bit[4], 2));
endmodule

bind cfgbit_locator cfgbit_locator_chk #(.J_W(J_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bit(req_bit),
    .rsp_valid(rsp_valid), .rsp_minor(rsp_minor), .rsp_bit(rsp_bit)
);

// File: tb/cfgbit_locator_tb_top.sv
module cfgbit_locator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic map_we = 1'b0;
    logic [3:0] map_idx = '0;
    logic [7:0] map_val = '0;
    logic req_valid = 1'b0;
    logic [15:0] req_bit = '0;
    logic [3:0] req_x = '0;
    logic [5:0] req_y = '0;
    logic [5:0] dev_rows = '0;
    logic [7:0] dev_flen = '0;
    logic signed [11:0] dev_k = '0;
    logic rsp_valid;
    logic [7:0] rsp_major;
    logic [7:0] rsp_minor;
    logic signed [23:0] rsp_byte;
    logic [2:0] rsp_bit;
    logic rsp_neg;

    cfgbit_locator dut_i (
        .clk(clk), .rst_n(rst_n),
        .map_we(map_we), .map_idx(map_idx), .map_val(map_val),
        .req_valid(req_valid), .req_bit(req_bit), .req_x(req_x), .req_y(req_y),
        .dev_rows(dev_rows), .dev_flen(dev_flen), .dev_k(dev_k),
        .rsp_valid(rsp_valid), .rsp_major(rsp_major), .rsp_minor(rsp_minor),
        .rsp_byte(rsp_byte), .rsp_bit(rsp_bit), .rsp_neg(rsp_neg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    cyc;
        int    major;
        int    minor;
        int    byte_o;
        int    bit_o;
        int    neg;
        string tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int map_m [16];
    int lane_t [16] = '{6, 4, 2, 0, -4, -6, -8, -10, -16, -18, -20, -22, -26, -28, -30, -32};
    int pos_t [8] = '{3, 2, 1, 0, 4, 5, 6, 7};
    int cur_rows = 0, cur_flen = 0, cur_k = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                chk("R2 unrequested response", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R2 latency", cyc - e.cyc, 2);
                chk("R4 major", int'(rsp_major), e.major);
                chk("R3 minor", int'(rsp_minor), e.minor);
                chk({e.tag, " byte offset"}, int'(rsp_byte), e.byte_o);
                chk("R8 bit offset", int'(rsp_bit), e.bit_o);
                chk("R9 negative flag", int'(rsp_neg), e.neg);
            end
        end
    end

    task automatic set_dev(int rows, int flen, int k);
        cur_rows = rows; cur_flen = flen; cur_k = k;
        dev_rows = 6'(rows); dev_flen = 8'(flen); dev_k = 12'(k);
    endtask

    task automatic issue(int j, int x, int y, string tag);
        exp_t e;
        int p;
        req_valid = 1'b1;
        req_bit = 16'(j); req_x = 4'(x); req_y = 6'(y);
        p = pos_t[(j >> 5) & 7];
        e.cyc    = cyc;
        e.major  = map_m[x];
        e.minor  = j >> 8;
        e.byte_o = (cur_rows - y) * 40 + 80 + cur_k + lane_t[j % 16]
                   + ((((j >> 4) & 1) == 1) ? -1 : 0) + (j >> 8) * cur_flen * 4;
        e.bit_o  = (((j >> 4) & 1) == 1) ? 7 - p : p;
        e.neg    = (e.byte_o < 0) ? 1 : 0;
        e.tag    = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic map_write(int idx, int val);
        map_we = 1'b1; map_idx = 4'(idx); map_val = 8'(val);
        map_m[idx] = val;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 20 && q.size() != 0; i++) @(negedge clk);
        if (q.size() != 0) begin
            chk("R2 missing response", q.size(), 0);
            q.delete();
        end
        @(negedge clk);
    endtask

    // R1: reset state and empty table
    task automatic t_reset();
        chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
        set_dev(8, 16, 0);
        issue(5, 3, 1, "R1");
        issue(40, 15, 0, "R1");
        drain();
    endtask

    // R4: table write then immediate use
    task automatic t_table();
        map_write(3, 8'hA5);
        issue(2, 3, 2, "R4");
        map_write(7, 17);
        map_write(0, 200);
        issue(17, 7, 4, "R4");
        issue(18, 0, 4, "R4");
        issue(19, 3, 4, "R4");
        drain();
    endtask

    // R5 R6: full sweep of two groups back to back
    task automatic t_lane_sweep();
        set_dev(10, 20, 5);
        for (int j = 0; j < 32; j++) issue(j, 3, 2, (j < 16) ? "R5" : "R6");
        drain();
    endtask

    // R8: all selector values in both group parities
    task automatic t_bit_order();
        set_dev(12, 30, 0);
        for (int s = 0; s < 8; s++) begin
            issue(32 * s + 3, 7, 1, "R8");
            issue(32 * s + 16 + 9, 7, 1, "R8");
        end
        drain();
    endtask

    // R3 R7: multi-frame indices and different frame lengths
    task automatic t_frames();
        set_dev(16, 100, 0);
        issue(256 * 3 + 5, 0, 3, "R7");
        issue(256 * 255 + 31, 0, 3, "R7");
        set_dev(16, 255, 7);
        issue(256 * 255 + 255, 3, 0, "R7");
        issue(256 * 1, 3, 16, "R7");
        drain();
    endtask

    // R9 R10: row above row count, negative device offset
    task automatic t_signed();
        set_dev(4, 10, -100);
        issue(12, 3, 10, "R10");
        issue(0, 3, 63, "R10");
        set_dev(0, 1, -80);
        issue(3, 3, 0, "R9");   // 0 - 0 + 80 - 80 + 0 = 0, not negative
        issue(4, 3, 0, "R9");   // -4, negative
        set_dev(63, 0, 2047);
        issue(0, 3, 0, "R10");
        drain();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) map_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table();
        t_lane_sweep();
        t_bit_order();
        t_frames();
        t_signed();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule